// File: doc/BRIEF.md
# SDR SDRAM Command Protocol Checker

This block is a passive observer for a four-bank single-data-rate SDRAM command bus. On every rising clock edge it samples chip select, the three command strobes, the bank bits and address line 10, decodes the command, and judges it against the bus rules. It never drives the bus.

To judge each command it keeps a small model of the memory. For each bank it holds the open or closed state, the age of the last activate and a lockout that counts down after a precharge. Shared timers cover the mode-register recovery, the spacing of activates across banks and the column lockout of an auto-precharge burst. Each broken rule sets its own sticky error bit. A saturating counter records how many cycles carried at least one violation, so a bench or an emulation harness can fail a run on a single read of two outputs.

All timing limits are given in nanoseconds together with a clock period, and are turned into cycle counts at elaboration.

Top module: `sdram_proto_checker`

## Requirements
- R1: Commands are decoded as {ras_n,cas_n,we_n}: 111 no-op, 011 activate, 101 read, 100 write, 110 burst stop, 010 precharge, 001 refresh, 000 mode set. A cycle with cs_n high is a no-op. After reset both `err_flags` and `viol_count` are zero, and a legal command stream leaves them at zero.
- R2: A refresh or mode set while any bank is open sets err_flags bit 0.
- R3: Any command other than a no-op fewer than T_MRD (2) cycles after a mode set sets bit 1. The first command allowed is 2 cycles after the mode set.
- R4: A read or write to an open bank fewer than 2 cycles (20 ns) after that bank's activate sets bit 2. Column commands on consecutive cycles are legal.
- R5: A precharge that closes an open bank fewer than 5 cycles (50 ns) after that bank's activate sets bit 3.
- R6: An activate to a bank other than the last activated one, fewer than 2 cycles (20 ns) after that activate, sets bit 4.
- R7: An activate fewer than 7 cycles (70 ns) after the previous activate of the same bank sets bit 5.
- R8: A precharge with a10 high closes all four banks, whatever the value of ba.
- R9: A read or write with a10 high to an open bank starts an auto-precharge burst of BURST_LEN (4) cycles and closes the bank. A read or write to any bank during the next BURST_LEN-1 cycles sets bit 6.
- R10: An activate to a closed bank sets bit 7 if it comes fewer than 2 cycles (20 ns) after that bank's precharge, or fewer than BURST_LEN+2 cycles after its auto-precharge command.
- R11: A read or write to a closed bank sets bit 8. An activate to an open bank sets bit 9.
- R12: Error bits stay set until reset. `viol_count` rises by one on each cycle that has at least one violation, and saturates at its maximum (255).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank select |
| a10 | input | 1 | Address bit 10: auto-precharge or precharge-all |
| err_flags | output | 10 | Sticky error bits, one per rule |
| viol_count | output | 8 | Saturating count of cycles with a violation |

## Verification
The bench goes after the edges of each timing window: a command one cycle early against one exactly on time. A checker with an off-by-one counter would flag the legal case or miss the early one.

A precharge-all with an arbitrary bank field is followed by a read to a bank that was open. A checker that honoured ba would leave that bank open and raise no idle-access error.

An auto-precharge write is followed by an access to another bank inside the burst, and then by activates just before and just after the lockout. A design that measured the lockout from the command instead of from the burst end would accept the early activate.

Long runs of violations push the counter to saturation, which catches wrap-around.

// File: rtl/sdr_chk_pkg.sv
// Shared types and helpers for the SDRAM protocol checker.
// Assumes the usual active-low command strobe encoding.
package sdr_chk_pkg;

    typedef enum logic [2:0] {
        C_NOP, C_ACT, C_RD, C_WR, C_BST, C_PRE, C_REF, C_MRS
    } cmd_e;

    localparam int ERR_N      = 10;
    localparam int E_MODE     = 0;
    localparam int E_MRD      = 1;
    localparam int E_RCD      = 2;
    localparam int E_RAS      = 3;
    localparam int E_RRD      = 4;
    localparam int E_RC       = 5;
    localparam int E_AP_BUSY  = 6;
    localparam int E_RP       = 7;
    localparam int E_IDLE     = 8;
    localparam int E_OPEN     = 9;

    // Round a time up to whole clock cycles.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Turn the sampled strobes into a command.
    function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n);
        cmd_e c;
        if (cs_n) begin
            c = C_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  c = C_NOP;
                3'b011:  c = C_ACT;
                3'b101:  c = C_RD;
                3'b100:  c = C_WR;
                3'b110:  c = C_BST;
                3'b010:  c = C_PRE;
                3'b001:  c = C_REF;
                default: c = C_MRS;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/sdr_cmd_decode.sv
// Command decoder: maps the raw strobes to a command and marks column commands.
// Purely combinational; a deselected cycle counts as a no-op.
module sdr_cmd_decode
    import sdr_chk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd,
    output logic is_col
);

    // Decode the command and flag reads and writes.
    always_comb begin
        cmd    = decode_cmd(cs_n, ras_n, cas_n, we_n);
        is_col = (cmd == C_RD) || (cmd == C_WR);
    end

endmodule

// File: rtl/sdr_bank_tracker.sv
// Per-bank tracker: open/closed state, age since the last activate, and a
// lockout counter until a new activate is allowed after a precharge.
// Assumes all timing limits are at least one cycle.
module sdr_bank_tracker
    import sdr_chk_pkg::*;
#(
    parameter int BANK_ID   = 0,
    parameter int BANK_W    = 2,
    parameter int T_RCD     = 2,
    parameter int T_RAS     = 5,
    parameter int T_RC      = 7,
    parameter int T_RP      = 2,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic              is_col,
    input  logic [BANK_W-1:0] ba,
    input  logic              a10,
    output logic              active,
    output logic              err_rcd,
    output logic              err_ras,
    output logic              err_rc,
    output logic              err_rp,
    output logic              err_idle,
    output logic              err_open
);

    localparam int AGE_MAX0 = (T_RC > T_RAS) ? T_RC : T_RAS;
    localparam int AGE_MAX  = (AGE_MAX0 > T_RCD) ? AGE_MAX0 : T_RCD;
    localparam int AGE_W    = $clog2(AGE_MAX + 1);
    localparam int LOCK_MAX = BURST_LEN + T_RP - 1;
    localparam int LOCK_W   = $clog2(LOCK_MAX + 1);

    localparam logic [AGE_W-1:0]  AGE_SAT = AGE_W'(AGE_MAX);
    localparam logic [AGE_W-1:0]  LIM_RCD = AGE_W'(T_RCD);
    localparam logic [AGE_W-1:0]  LIM_RAS = AGE_W'(T_RAS);
    localparam logic [AGE_W-1:0]  LIM_RC  = AGE_W'(T_RC);
    localparam logic [LOCK_W-1:0] LOCK_PRE = LOCK_W'(T_RP - 1);
    localparam logic [LOCK_W-1:0] LOCK_AP  = LOCK_W'(LOCK_MAX);

    logic [AGE_W-1:0]  age;
    logic [LOCK_W-1:0] lock;
    logic hit, act_hit, col_hit, pre_hit;

    // Work out which parts of the current command touch this bank.
    always_comb begin
        hit     = (ba == BANK_W'(BANK_ID));
        act_hit = (cmd == C_ACT) && hit;
        col_hit = is_col && hit;
        pre_hit = (cmd == C_PRE) && (hit || a10);
    end

    // Judge the current command against this bank's state.
    always_comb begin
        err_idle = col_hit && !active;
        err_rcd  = col_hit && active && (age < LIM_RCD);
        err_ras  = pre_hit && active && (age < LIM_RAS);
        err_open = act_hit && active;
        err_rc   = act_hit && (age < LIM_RC);
        err_rp   = act_hit && !active && (lock != '0);
    end

    // Update the bank state, the activate age and the lockout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            age    <= AGE_SAT;
            lock   <= '0;
        end else begin
            if (age != AGE_SAT) age <= age + AGE_W'(1);
            if (lock != '0)     lock <= lock - LOCK_W'(1);
            if (act_hit) begin
                active <= 1'b1;
                age    <= AGE_W'(1);
                lock   <= '0;
            end else if (pre_hit && active) begin
                active <= 1'b0;
                lock   <= LOCK_PRE;
            end else if (col_hit && a10 && active) begin
                active <= 1'b0;
                lock   <= LOCK_AP;
            end
        end
    end

    // R10: a pending lockout only exists while the bank is closed.
    p_lock_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lock != '0) |-> !active);

    // R9: an auto-precharge access closes the bank and starts its lockout.
    p_ap_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (col_hit && a10 && active) |=> (!active && lock != '0));

endmodule

// File: rtl/sdr_bus_timer.sv
// Bus-wide timers: mode-set recovery, activate-to-activate spacing across
// banks, and the column lockout during an auto-precharge burst.
// Assumes bank_active reflects the state before the current command.
module sdr_bus_timer
    import sdr_chk_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int NUM_BANKS = 4,
    parameter int T_RRD     = 2,
    parameter int T_MRD     = 2,
    parameter int BURST_LEN = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  cmd_e                 cmd,
    input  logic                 is_col,
    input  logic [BANK_W-1:0]    ba,
    input  logic                 a10,
    input  logic [NUM_BANKS-1:0] bank_active,
    output logic                 err_mode,
    output logic                 err_mrd,
    output logic                 err_rrd,
    output logic                 err_ap
);

    localparam int MRD_W = $clog2(T_MRD + 1);
    localparam int RRD_W = $clog2(T_RRD + 1);
    localparam int AP_W  = $clog2(BURST_LEN + 1);

    localparam logic [MRD_W-1:0] MRD_LOAD = MRD_W'(T_MRD - 1);
    localparam logic [RRD_W-1:0] RRD_SAT  = RRD_W'(T_RRD);
    localparam logic [AP_W-1:0]  AP_LOAD  = AP_W'(BURST_LEN - 1);

    logic [MRD_W-1:0]  mrd_wait;
    logic [RRD_W-1:0]  rrd_age;
    logic [AP_W-1:0]   ap_wait;
    logic [BANK_W-1:0] last_bank;
    logic              ap_start;

    // Judge the current command against the shared timers.
    always_comb begin
        ap_start = is_col && a10 && bank_active[ba];
        err_mode = ((cmd == C_REF) || (cmd == C_MRS)) && (|bank_active);
        err_mrd  = (cmd != C_NOP) && (mrd_wait != '0);
        err_rrd  = (cmd == C_ACT) && (ba != last_bank) && (rrd_age < RRD_SAT);
        err_ap   = is_col && (ap_wait != '0);
    end

    // Advance the shared timers and reload them on the commands that start them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mrd_wait  <= '0;
            rrd_age   <= RRD_SAT;
            ap_wait   <= '0;
            last_bank <= '0;
        end else begin
            if (mrd_wait != '0) mrd_wait <= mrd_wait - MRD_W'(1);
            if (rrd_age != RRD_SAT) rrd_age <= rrd_age + RRD_W'(1);
            if (ap_wait != '0) ap_wait <= ap_wait - AP_W'(1);
            if (cmd == C_MRS) mrd_wait <= MRD_LOAD;
            if (cmd == C_ACT) begin
                rrd_age   <= RRD_W'(1);
                last_bank <= ba;
            end
            if (ap_start) ap_wait <= AP_LOAD;
        end
    end

    // R9: no burst lockout outlasts the burst length.
    p_ap_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_wait != '0 && !ap_start) |=> (ap_wait < $past(ap_wait)));

endmodule

// File: rtl/sdr_err_collect.sv
// Error collector: keeps sticky error bits and a saturating count of cycles
// that carried at least one violation.
module sdr_err_collect #(
    parameter int ERR_N = 10,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_N-1:0] err_now,
    output logic [ERR_N-1:0] err_flags,
    output logic [CNT_W-1:0] viol_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Accumulate the error bits and count violating cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flags  <= '0;
            viol_count <= '0;
        end else begin
            err_flags <= err_flags | err_now;
            if ((|err_now) && (viol_count != CNT_MAX))
                viol_count <= viol_count + CNT_W'(1);
        end
    end

    // R12: once set, an error bit stays set.
    p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    // R12: each violating cycle below saturation adds exactly one.
    p_count_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((|err_now) && (viol_count != CNT_MAX)) |=> (viol_count == $past(viol_count) + CNT_W'(1)));

endmodule

// File: rtl/sdram_proto_checker.sv
// Top of the SDRAM protocol checker. Passively samples the command bus,
// tracks every bank and the shared timers, and reports sticky errors.
// Timing limits are given in ns and converted with CLK_NS.
module sdram_proto_checker
    import sdr_chk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int CLK_NS    = 10,
    parameter int RCD_NS    = 20,
    parameter int RAS_NS    = 50,
    parameter int RRD_NS    = 20,
    parameter int RC_NS     = 70,
    parameter int RP_NS     = 20,
    parameter int MRD_CK    = 2,
    parameter int BURST_LEN = 4,
    parameter int CNT_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [$clog2(NUM_BANKS)-1:0] ba,
    input  logic                       a10,
    output logic [ERR_N-1:0]           err_flags,
    output logic [CNT_W-1:0]           viol_count
);

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int T_RCD  = ceil_div(RCD_NS, CLK_NS);
    localparam int T_RAS  = ceil_div(RAS_NS, CLK_NS);
    localparam int T_RRD  = ceil_div(RRD_NS, CLK_NS);
    localparam int T_RC   = ceil_div(RC_NS, CLK_NS);
    localparam int T_RP   = ceil_div(RP_NS, CLK_NS);

    cmd_e                 cmd;
    logic                 is_col;
    logic [NUM_BANKS-1:0] bank_active;
    logic [NUM_BANKS-1:0] b_rcd, b_ras, b_rc, b_rp, b_idle, b_open;
    logic                 g_mode, g_mrd, g_rrd, g_ap;
    logic [ERR_N-1:0]     err_now;

    sdr_cmd_decode u_dec (
        .cs_n   (cs_n),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .we_n   (we_n),
        .cmd    (cmd),
        .is_col (is_col)
    );

    for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
        sdr_bank_tracker #(
            .BANK_ID   (gb),
            .BANK_W    (BANK_W),
            .T_RCD     (T_RCD),
            .T_RAS     (T_RAS),
            .T_RC      (T_RC),
            .T_RP      (T_RP),
            .BURST_LEN (BURST_LEN)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd      (cmd),
            .is_col   (is_col),
            .ba       (ba),
            .a10      (a10),
            .active   (bank_active[gb]),
            .err_rcd  (b_rcd[gb]),
            .err_ras  (b_ras[gb]),
            .err_rc   (b_rc[gb]),
            .err_rp   (b_rp[gb]),
            .err_idle (b_idle[gb]),
            .err_open (b_open[gb])
        );
    end

    sdr_bus_timer #(
        .BANK_W    (BANK_W),
        .NUM_BANKS (NUM_BANKS),
        .T_RRD     (T_RRD),
        .T_MRD     (MRD_CK),
        .BURST_LEN (BURST_LEN)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .is_col      (is_col),
        .ba          (ba),
        .a10         (a10),
        .bank_active (bank_active),
        .err_mode    (g_mode),
        .err_mrd     (g_mrd),
        .err_rrd     (g_rrd),
        .err_ap      (g_ap)
    );

    // Gather the per-bank and shared error conditions into one vector.
    always_comb begin
        err_now            = '0;
        err_now[E_MODE]    = g_mode;
        err_now[E_MRD]     = g_mrd;
        err_now[E_RCD]     = |b_rcd;
        err_now[E_RAS]     = |b_ras;
        err_now[E_RRD]     = g_rrd;
        err_now[E_RC]      = |b_rc;
        err_now[E_AP_BUSY] = g_ap;
        err_now[E_RP]      = |b_rp;
        err_now[E_IDLE]    = |b_idle;
        err_now[E_OPEN]    = |b_open;
    end

    sdr_err_collect #(
        .ERR_N (ERR_N),
        .CNT_W (CNT_W)
    ) u_col (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_now    (err_now),
        .err_flags  (err_flags),
        .viol_count (viol_count)
    );

    // R8: a precharge with a10 high leaves every bank closed.
    p_pre_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == C_PRE && a10) |=> (bank_active == '0));

    // R11: an activate always leaves the addressed bank open.
    p_act_opens_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == C_ACT) |=> (bank_active[$past(ba)] == 1'b1));

endmodule

// File: tb/sdram_proto_checker_bench.sv
module sdram_proto_checker_bench;

    localparam logic [2:0] OP_NOP = 3'b111;
    localparam logic [2:0] OP_ACT = 3'b011;
    localparam logic [2:0] OP_RD  = 3'b101;
    localparam logic [2:0] OP_WR  = 3'b100;
    localparam logic [2:0] OP_PRE = 3'b010;
    localparam logic [2:0] OP_REF = 3'b001;
    localparam logic [2:0] OP_MRS = 3'b000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic       a10 = 1'b0;
    logic [9:0] err_flags;
    logic [7:0] viol_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state (cycle stamps).
    int   t;
    int   act_t[4];
    int   rdy_t[4];
    bit   open_m[4];
    int   mrs_t, lact_t, lact_b, ap_end;
    logic [9:0] exp_flags;
    int   exp_cnt;

    always #4 clk = ~clk;

    sdram_proto_checker u_sdram_proto_checker (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .a10(a10), .err_flags(err_flags), .viol_count(viol_count)
    );

    task automatic model_clear();
        t = 0; mrs_t = -1000; lact_t = -1000; lact_b = 0; ap_end = -1000;
        for (int k = 0; k < 4; k++) begin
            act_t[k] = -1000; rdy_t[k] = -1000; open_m[k] = 0;
        end
        exp_flags = '0; exp_cnt = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; cs_n = 1; {ras_n, cas_n, we_n} = OP_NOP; a10 = 0; ba = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_clear();
    endtask

    // One bus cycle: drive, predict, then compare every output.
    task automatic step(input logic [2:0] op, input int b, input bit ap, input bit desel = 0);
        logic [9:0] e;
        bit nop, col;
        bit any_open;
        @(negedge clk);
        cs_n = desel; {ras_n, cas_n, we_n} = op; ba = 2'(b); a10 = ap;
        e = '0;
        nop = desel || (op == OP_NOP);
        col = !desel && (op == OP_RD || op == OP_WR);
        any_open = open_m[0] | open_m[1] | open_m[2] | open_m[3];
        if (!desel && (op == OP_REF || op == OP_MRS) && any_open) e[0] = 1;   // R2
        if (!nop && (t - mrs_t) < 2) e[1] = 1;                                // R3
        if (col) begin
            if (!open_m[b]) e[8] = 1;                                         // R11
            else if ((t - act_t[b]) < 2) e[2] = 1;                            // R4
            if (t < ap_end) e[6] = 1;                                         // R9
        end
        if (!desel && op == OP_PRE)
            for (int k = 0; k < 4; k++)
                if ((ap || k == b) && open_m[k] && (t - act_t[k]) < 5) e[3] = 1;   // R5
        if (!desel && op == OP_ACT) begin
            if (open_m[b]) e[9] = 1;                                          // R11
            if ((t - act_t[b]) < 7) e[5] = 1;                                 // R7
            if (b != lact_b && (t - lact_t) < 2) e[4] = 1;                    // R6
            if (!open_m[b] && t < rdy_t[b]) e[7] = 1;                         // R10
        end
        // state update
        if (!desel && op == OP_ACT) begin
            open_m[b] = 1; act_t[b] = t; rdy_t[b] = t; lact_t = t; lact_b = b;
        end else if (!desel && op == OP_PRE) begin
            for (int k = 0; k < 4; k++)
                if ((ap || k == b) && open_m[k]) begin open_m[k] = 0; rdy_t[k] = t + 2; end
        end else if (col && ap && open_m[b]) begin
            open_m[b] = 0; rdy_t[b] = t + 6; ap_end = t + 4;
        end
        if (!desel && op == OP_MRS) mrs_t = t;
        exp_flags = exp_flags | e;
        if (e != 0 && exp_cnt < 255) exp_cnt++;
        t++;
        @(posedge clk);
        #2;
        checks++;
        if (err_flags !== exp_flags || viol_count !== 8'(exp_cnt)) begin
            errors++;
            $display("FAIL R12 model cycle %0d: flags %b cnt %0d, expected %b cnt %0d",
                     t, err_flags, viol_count, exp_flags, exp_cnt);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(OP_NOP, 0, 0);
    endtask

    task automatic check_flags(input string rq, input logic [9:0] mask, input logic [9:0] want);
        checks++;
        if ((err_flags & mask) !== want) begin
            errors++;
            $display("FAIL %s: flags %b (mask %b), expected %b", rq, err_flags & mask, mask, want);
        end
    endtask

    task automatic check_count(input string rq, input int want);
        checks++;
        if (viol_count !== 8'(want)) begin
            errors++;
            $display("FAIL %s: count %0d, expected %0d", rq, viol_count, want);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        #2;
        check_flags("R1 reset", '1, '0);
        check_count("R1 reset", 0);

        // R1/R4: legal stream, back-to-back column commands, deselects
        step(OP_ACT, 0, 0);
        step(OP_RD, 2, 0, 1);
        step(OP_RD, 0, 0);
        step(OP_WR, 0, 0);
        step(OP_NOP, 0, 0);
        step(OP_PRE, 0, 0);
        check_flags("R1 legal", '1, '0);
        check_flags("R4 tCCD=1", 10'b0000000100, 10'b0);

        // R4: read one cycle after activate
        step(OP_ACT, 1, 0);
        step(OP_RD, 1, 0);
        check_flags("R4 early read", 10'b0000000100, 10'b0000000100);

        // R5: precharge two cycles after activate
        do_reset();
        step(OP_ACT, 1, 0);
        step(OP_NOP, 0, 0);
        step(OP_PRE, 1, 0);
        check_flags("R5 early precharge", '1, 10'b0000001000);

        // R6: activates to different banks back to back
        do_reset();
        step(OP_ACT, 0, 0);
        step(OP_ACT, 1, 0);
        step(OP_NOP, 0, 0);
        step(OP_ACT, 2, 0);
        check_flags("R6 rrd", '1, 10'b0000010000);

        // R7/R10: legal reopen at limits, then an early reopen
        do_reset();
        step(OP_ACT, 0, 0);
        idle(4);
        step(OP_PRE, 0, 0);
        step(OP_NOP, 0, 0);
        step(OP_ACT, 0, 0);
        check_flags("R7 R10 on-time reopen", '1, '0);
        step(OP_ACT, 3, 0);
        idle(4);
        step(OP_PRE, 3, 0);
        step(OP_ACT, 3, 0);
        check_flags("R7 early reopen", 10'b0000100000, 10'b0000100000);
        check_flags("R10 early reopen after precharge", 10'b0010000000, 10'b0010000000);

        // R2/R8: mode set while open, precharge-all with ba=3, then refresh
        do_reset();
        step(OP_ACT, 0, 0);
        step(OP_NOP, 0, 0);
        step(OP_ACT, 2, 0);
        step(OP_MRS, 0, 0);
        idle(3);
        step(OP_PRE, 3, 1);
        step(OP_NOP, 0, 0);
        step(OP_REF, 0, 0);
        check_flags("R2 mode set while open", '1, 10'b0000000001);
        step(OP_RD, 0, 0);
        check_flags("R8 precharge-all closed bank 0", 10'b0100000000, 10'b0100000000);
        check_count("R12 count", 2);

        // R3: mode-set recovery
        do_reset();
        step(OP_MRS, 0, 0);
        step(OP_NOP, 0, 0);
        step(OP_ACT, 0, 0);
        check_flags("R3 on-time command", '1, '0);
        step(OP_PRE, 0, 1);
        idle(2);
        step(OP_MRS, 0, 0);
        step(OP_REF, 0, 0);
        check_flags("R3 early command", 10'b0000000010, 10'b0000000010);

        // R9/R10: auto-precharge burst lockout
        do_reset();
        step(OP_ACT, 1, 0);
        step(OP_NOP, 0, 0);
        step(OP_ACT, 0, 0);
        step(OP_NOP, 0, 0);
        step(OP_WR, 0, 1);
        step(OP_NOP, 0, 0);
        step(OP_RD, 1, 0);
        check_flags("R9 access during burst", '1, 10'b0001000000);
        idle(1);
        step(OP_RD, 1, 0);
        check_flags("R9 access after burst", '1, 10'b0001000000);
        step(OP_ACT, 0, 0);
        check_flags("R10 early activate after auto-precharge", 10'b0010000000, 10'b0010000000);

        // R10: on-time activate after auto-precharge is clean
        do_reset();
        step(OP_ACT, 2, 0);
        step(OP_NOP, 0, 0);
        step(OP_RD, 2, 1);
        idle(5);
        step(OP_ACT, 2, 0);
        check_flags("R10 on-time activate after auto-precharge", '1, '0);

        // R11: activate to open bank, access to idle bank
        step(OP_ACT, 2, 0);
        check_flags("R11 activate open bank", 10'b1000000000, 10'b1000000000);
        step(OP_WR, 3, 0);
        check_flags("R11 access idle bank", 10'b0100000000, 10'b0100000000);

        // R12: stickiness and saturation
        idle(10);
        check_flags("R12 sticky", 10'b1100000000, 10'b1100000000);
        for (int i = 0; i < 300; i++) step(OP_RD, 1, 0);
        check_count("R12 saturation", 255);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule